// File: doc/BRIEF.md
# Circular-Buffer Address Post-Increment Unit

This unit computes the value an address register takes after a memory access. The access advances the register by a power-of-two step of 1, 2 or 4 bytes. A mode bit turns on circular-buffer behaviour. In that mode, when the register sits on the last aligned slot of a ring, it reloads the ring's start value. Otherwise it keeps counting.

The caller presents the current address, a step code, the mode bit and the two ring bounds, and pulses `req_valid` for one cycle. One clock later the unit returns the next address with a one-cycle `res_valid`. The result also carries a flag that marks a reload and a flag that marks an illegal step code. The unit is meant to sit beside a register file's write-back port, so the result can be written straight back into the register.

Top module: `addr_postinc`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request, `res_valid`, `wrap_hit` and `step_err` are 0 and `next_addr` is 0.
- R2: With `modulo_on` = 0 and a legal step, `next_addr` = (`cur_addr` + step) mod 2^16 and `wrap_hit` = 0, even when `cur_addr` equals `ring_end`.
- R3: With `modulo_on` = 1 and a legal step, when `cur_addr` equals `ring_end` rounded down to a multiple of the step, `next_addr` = `ring_start` and `wrap_hit` = 1.
- R4: With `modulo_on` = 1, a legal step and no such match, `next_addr` = (`cur_addr` + step) mod 2^16 and `wrap_hit` = 0.
- R5: Step encoding on `step_sel`: 0 selects 1, 1 selects 2, 2 selects 4.
- R6: `step_sel` = 3 is illegal. For that code `next_addr` = `cur_addr`, `step_err` = 1 and `wrap_hit` = 0, whatever the mode and bounds are.
- R7: Each request sampled with `req_valid` = 1 at a rising edge produces its result, with `res_valid` = 1, right after that same edge. Back-to-back requests give back-to-back results.
- R8: After an edge where `req_valid` = 0, `res_valid`, `wrap_hit` and `step_err` are 0 and `next_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per update |
| cur_addr | input | 16 | Address register value before the update |
| step_sel | input | 2 | Step code (0:1, 1:2, 2:4, 3:illegal) |
| modulo_on | input | 1 | Circular-buffer mode enable |
| ring_start | input | 16 | Address reloaded on a wrap |
| ring_end | input | 16 | Last address of the ring, before alignment |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| next_addr | output | 16 | Updated address value |
| wrap_hit | output | 1 | Set for a result that reloaded `ring_start` |
| step_err | output | 1 | Set for a result whose step code was illegal |

## Verification
The clocked properties compare each result against the inputs of the cycle before it. They therefore assume the caller holds `req_valid` low during reset, and that request inputs are only meaningful in cycles with `req_valid` high. The bench drives every request on the falling edge for exactly one cycle and keeps `req_valid` low through reset. The bench sends both back-to-back requests and requests separated by idle gaps. Its ring bounds are chosen so that the end value is unaligned for the larger steps, so the rounded-down compare is what decides the match.

// File: rtl/addr_postinc_pkg.sv
package addr_postinc_pkg;
  localparam int ADDR_W    = 16;
  localparam int SEL_W     = 2;
  localparam int NUM_STEPS = 3;

  // Step size in bytes for a legal code: a power of two.
  function automatic logic [ADDR_W-1:0] step_bytes(input logic [SEL_W-1:0] code);
    return ADDR_W'(1) << code;
  endfunction

  // Clear the low bits of an address below the step alignment.
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] step);
    return a & ~(step - ADDR_W'(1));
  endfunction
endpackage

// File: rtl/step_decode.sv
module step_decode
  import addr_postinc_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int SW     = SEL_W,
  parameter int NSTEPS = NUM_STEPS
) (
  input  logic [SW-1:0] sel,
  output logic [AW-1:0] step,
  output logic          legal
);
  logic [NSTEPS-1:0] hit;

  for (genvar g = 0; g < NSTEPS; g++) begin : g_code
    assign hit[g] = (sel == SW'(g));
  end

  always_comb begin
    step  = '0;
    legal = |hit;
    for (int i = 0; i < NSTEPS; i++) begin
      if (hit[i]) step = AW'(1) << i;
    end
  end
endmodule

// File: rtl/wrap_detect.sv
module wrap_detect
  import addr_postinc_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ring_last,
  input  logic [AW-1:0] step,
  input  logic          mode_on,
  input  logic          legal,
  output logic          match
);
  logic [AW-1:0] last_aligned;

  assign last_aligned = align_down(ring_last, step);
  assign match        = mode_on && legal && (cur == last_aligned);
endmodule

// File: rtl/addr_postinc.sv
module addr_postinc
  import addr_postinc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] cur_addr,
  input  logic [SW-1:0] step_sel,
  input  logic          modulo_on,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_end,
  output logic          res_valid,
  output logic [AW-1:0] next_addr,
  output logic          wrap_hit,
  output logic          step_err
);
  // Named internal events, brought out for the assertions.
  logic [AW-1:0] step_val;
  logic          step_legal;
  logic          wrap_match;
  logic [AW-1:0] sum_addr;
  logic [AW-1:0] next_comb;

  step_decode #(.AW(AW), .SW(SW)) u_dec (
    .sel   (step_sel),
    .step  (step_val),
    .legal (step_legal)
  );

  wrap_detect #(.AW(AW)) u_wrap (
    .cur       (cur_addr),
    .ring_last (ring_end),
    .step      (step_val),
    .mode_on   (modulo_on),
    .legal     (step_legal),
    .match     (wrap_match)
  );

  assign sum_addr = cur_addr + step_val;

  always_comb begin
    if (!step_legal)     next_comb = cur_addr;
    else if (wrap_match) next_comb = ring_start;
    else                 next_comb = sum_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      next_addr <= '0;
      wrap_hit  <= 1'b0;
      step_err  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      wrap_hit  <= req_valid && wrap_match;
      step_err  <= req_valid && !step_legal;
      if (req_valid) next_addr <= next_comb;
    end
  end

  // R3: a reload only follows a request made in circular mode
  assert_wrap_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |-> ($past(req_valid) && $past(modulo_on) && next_addr == $past(ring_start)));

  // R6: an illegal code never reloads and never moves the address
  assert_illegal_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && step_sel == SW'(3)) |=> (step_err && !wrap_hit && next_addr == $past(cur_addr)));

  // R2: plain counting in linear mode
  assert_linear_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !modulo_on && step_sel != SW'(3)) |=>
      (!wrap_hit && next_addr == AW'($past(cur_addr) + (AW'(1) << $past(step_sel)))));

  // R8: idle cycles keep the outputs quiet and the address held
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !wrap_hit && !step_err && $stable(next_addr)));

  // R7: flags only appear together with a result
  assert_flags_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hit || step_err) |-> res_valid);
endmodule

// File: tb/tb_addr_postinc.sv
module tb_addr_postinc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] cur_addr = '0;
  logic [1:0]  step_sel = '0;
  logic        modulo_on = 1'b0;
  logic [15:0] ring_start = '0;
  logic [15:0] ring_end = '0;
  logic        res_valid;
  logic [15:0] next_addr;
  logic        wrap_hit;
  logic        step_err;

  always #2.5 clk = ~clk;

  addr_postinc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_addr(cur_addr),
    .step_sel(step_sel), .modulo_on(modulo_on), .ring_start(ring_start),
    .ring_end(ring_end), .res_valid(res_valid), .next_addr(next_addr),
    .wrap_hit(wrap_hit), .step_err(step_err)
  );

  typedef struct {
    logic [15:0] addr;
    logic        wrap;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Expected result, written from the requirements in a form of its own.
  function automatic exp_t model(input logic [15:0] cur, input logic [1:0] sel,
                                 input logic mode, input logic [15:0] st,
                                 input logic [15:0] en, input string tag);
    exp_t e;
    int   sz;
    int   last;
    e.tag = tag;
    e.wrap = 1'b0;
    e.err = 1'b0;
    if (sel == 2'd3) begin
      e.addr = cur;
      e.err = 1'b1;
    end else begin
      sz = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
      last = int'(en) - (int'(en) % sz);
      if (mode && int'(cur) == last) begin
        e.addr = st;
        e.wrap = 1'b1;
      end else begin
        e.addr = 16'((int'(cur) + sz) % 65536);
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Driver: one request for one cycle, expected item pushed to the scoreboard.
  task automatic drive(input logic [15:0] cur, input logic [1:0] sel, input logic mode,
                       input logic [15:0] st, input logic [15:0] en, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    cur_addr   = cur;
    step_sel   = sel;
    modulo_on  = mode;
    ring_start = st;
    ring_end   = en;
    exp_q.push_back(model(cur, sel, mode, st, en, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops and compares whenever a result shows up.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected result", 16'(res_valid), 16'd0);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " addr"}, next_addr, e.addr);
          check({e.tag, " wrap"}, 16'(wrap_hit), 16'(e.wrap));
          check({e.tag, " err"}, 16'(step_err), 16'(e.err));
        end
      end
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 res_valid", 16'(res_valid), 16'd0);
    check("R1 next_addr", next_addr, 16'd0);
    check("R1 flags", {14'd0, wrap_hit, step_err}, 16'd0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", {13'd0, res_valid, wrap_hit, step_err}, 16'd0);
    check("R1 addr after release", next_addr, 16'd0);

    // R2 / R5: linear mode, each step code
    drive(16'h1234, 2'd0, 1'b0, 16'h0000, 16'h0000, "R2 R5 step1");
    drive(16'h1234, 2'd1, 1'b0, 16'h0000, 16'h0000, "R2 R5 step2");
    drive(16'h1234, 2'd2, 1'b0, 16'h0000, 16'h0000, "R2 R5 step4");
    drive(16'hFFFF, 2'd1, 1'b0, 16'h0000, 16'h0000, "R2 rollover");
    drive(16'h2010, 2'd2, 1'b0, 16'h2000, 16'h2010, "R2 at end linear");
    idle(2);

    // R3: reloads with unaligned ends
    drive(16'h2010, 2'd0, 1'b1, 16'h2000, 16'h2010, "R3 step1 reload");
    drive(16'h2010, 2'd1, 1'b1, 16'h2000, 16'h2011, "R3 step2 reload");
    drive(16'h2010, 2'd2, 1'b1, 16'h2000, 16'h2013, "R3 step4 reload");
    idle(1);

    // R4: circular mode without a match
    drive(16'h2013, 2'd2, 1'b1, 16'h2000, 16'h2013, "R4 unaligned no match");
    drive(16'h2005, 2'd0, 1'b1, 16'h2000, 16'h2010, "R4 inside ring");
    drive(16'hFFFE, 2'd1, 1'b1, 16'h2000, 16'h2010, "R4 rollover");

    // R6: illegal code, even on a matching address
    drive(16'h2010, 2'd3, 1'b1, 16'h2000, 16'h2010, "R6 illegal match");
    drive(16'h0abc, 2'd3, 1'b0, 16'h2000, 16'h2010, "R6 illegal linear");

    // R7: a walk around a small ring, back to back
    for (int k = 0; k < 6; k++) begin
      drive(16'(16'h3000 + 2 * (k % 4)), 2'd1, 1'b1, 16'h3000, 16'h3007, "R7 ring walk");
    end

    // R8: idle gap holds the address
    idle(1);
    @(negedge clk);
    held = next_addr;
    idle(3);
    check("R8 no result", {14'd0, res_valid, wrap_hit}, 16'd0);
    check("R8 address held", next_addr, held);
    check("R8 no error", 16'(step_err), 16'd0);
    check("R7 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule